// File: doc/BRIEF.md
# Symmetric Kernel Shift-Add Dot Product

This block takes a complete 3×3 window of unsigned pixels in one cycle and returns the weighted sum of all nine pixels five cycles later. The kernel is mirror-symmetric in both axes, so it has only three distinct coefficients: one for the middle pixel, one shared by the four pixels that touch the middle along a row or column, and one shared by the four corner pixels. Each coefficient is a signed power of two. Every tap is therefore a left shift with an optional negation, and the block uses no multiplier.

The coefficients are loaded through a small write port while the datapath is idle, typically once at start-up. After that, windows can be presented on every clock. The nine shifted terms are registered together. A four-level registered adder tree then reduces them to a single signed sum whose width cannot overflow.

Top module: `symkern_dot`

## Requirements
- R1: For a window whose pixel p (p = 0..8, raster order) occupies `win_pix[8p+7:8p]`, the result equals the sum over p of pixel p times its coefficient. Pixel 4 uses the middle coefficient, pixels 1, 3, 5 and 7 use the side coefficient, and pixels 0, 2, 6 and 8 use the corner coefficient.
- R2: A coefficient code is 4 bits. Bit 3 is the sign (1 = negative) and bits 2:0 are the shift k, giving a value of ±2^k for k from 0 to 7.
- R3: `cfg_sel` picks the coefficient that a write with `cfg_we` high replaces: 0 selects the middle, 1 the side, 2 the corner. A write with value 3 changes no coefficient.
- R4: A coefficient write is ignored when `win_valid` is high in the same cycle, or was high in any of the 4 previous cycles. A write in the 5th cycle after the last window takes effect.
- R5: `dot_valid` is high exactly 5 cycles after each cycle with `win_valid` high. Back-to-back windows give back-to-back results.
- R6: `dot_sum` is a 20-bit two's-complement value. It is exact at the extremes: all pixels 255 with all coefficients +128 gives +293760, and with all coefficients −128 gives −293760.
- R7: After synchronous reset, `dot_valid` is low and all three coefficients are +1 (code 0), so the first result is the plain sum of the pixels.
- R8: `dot_valid` stays low in every cycle that does not follow a `win_valid` cycle by exactly 5 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Coefficient select: 0 middle, 1 side, 2 corner, 3 none |
| cfg_code | input | 4 | Coefficient code {sign, shift[2:0]} |
| win_valid | input | 1 | Window present on `win_pix` |
| win_pix | input | 72 | Nine 8-bit pixels, pixel p at bits 8p+7:8p |
| dot_valid | output | 1 | Result present on `dot_sum` |
| dot_sum | output | 20 | Signed weighted sum |

## Verification
The hardest case to reach is a coefficient write that arrives while earlier windows are still moving through the adder tree. In that case the write must be dropped, and the only evidence is in results produced later. The stimulus sends a single window and then attempts writes in each of the four following cycles. It also writes in the same cycle as a window, and then in the first free cycle. A window sent afterwards shows which of these writes took effect. Streams of random windows with gaps of random length, separated by random coefficient changes, cover the timing of the valid flag across every gap length.

// File: rtl/skdp_pkg.sv
package skdp_pkg;
  localparam int TAPS  = 9;
  localparam int SH_W  = 3;
  localparam int CODE_W = SH_W + 1;

  typedef enum logic [1:0] {
    SEL_MID    = 2'd0,
    SEL_SIDE   = 2'd1,
    SEL_CORNER = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic            neg;
    logic [SH_W-1:0] sh;
  } wcode_t;

  function automatic wsel_e tap_class(input int p);
    if (p == TAPS / 2) return SEL_MID;
    else if (p % 2 == 1) return SEL_SIDE;
    else return SEL_CORNER;
  endfunction
endpackage

// File: rtl/skdp_weight_bank.sv
module skdp_weight_bank
  import skdp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  wsel_e  sel,
  input  wcode_t wdata,
  input  logic   lock,
  output wcode_t w_mid,
  output wcode_t w_side,
  output wcode_t w_corner
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w_mid    <= '0;
      w_side   <= '0;
      w_corner <= '0;
    end else if (we && !lock) begin
      case (sel)
        SEL_MID:    w_mid    <= wdata;
        SEL_SIDE:   w_side   <= wdata;
        SEL_CORNER: w_corner <= wdata;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/skdp_shift_term.sv
module skdp_shift_term
  import skdp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 20
) (
  input  logic [PIX_W-1:0] pix,
  input  wcode_t           w,
  output logic [ACC_W-1:0] term
);
  logic [ACC_W-1:0] mag;
  assign mag  = {{(ACC_W-PIX_W){1'b0}}, pix} << w.sh;
  assign term = w.neg ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/skdp_add_level.sv
module skdp_add_level #(
  parameter int N_IN = 9,
  parameter int W    = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         vin,
  input  logic [N_IN*W-1:0]            din,
  output logic                         vout,
  output logic [((N_IN+1)/2)*W-1:0]    dout
);
  localparam int NP    = N_IN / 2;
  localparam int N_OUT = (N_IN + 1) / 2;

  logic [N_OUT*W-1:0] nxt;

  for (genvar i = 0; i < NP; i++) begin : g_pair
    assign nxt[i*W +: W] = din[2*i*W +: W] + din[(2*i+1)*W +: W];
  end

  if (N_IN % 2 == 1) begin : g_carry
    assign nxt[NP*W +: W] = din[(N_IN-1)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) vout <= 1'b0;
    else     vout <= vin;
  end

  always_ff @(posedge clk) begin
    if (vin) dout <= nxt;
  end
endmodule

// File: rtl/symkern_dot.sv
module symkern_dot
  import skdp_pkg::*;
#(
  parameter  int PIX_W = 8,
  localparam int ACC_W = PIX_W + (1 << SH_W) + $clog2(TAPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [CODE_W-1:0]     cfg_code,
  input  logic                  win_valid,
  input  logic [TAPS*PIX_W-1:0] win_pix,
  output logic                  dot_valid,
  output logic [ACC_W-1:0]      dot_sum
);
  localparam int N1 = TAPS;
  localparam int N2 = (N1 + 1) / 2;
  localparam int N3 = (N2 + 1) / 2;
  localparam int N4 = (N3 + 1) / 2;

  wcode_t w_mid, w_side, w_corner;
  logic   cfg_lock;
  logic   v1, v2, v3, v4;

  logic [N1*ACC_W-1:0] term_c, term_q;
  logic [N2*ACC_W-1:0] sum2;
  logic [N3*ACC_W-1:0] sum3;
  logic [N4*ACC_W-1:0] sum4;

  assign cfg_lock = win_valid | v1 | v2 | v3 | v4;

  skdp_weight_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .sel      (wsel_e'(cfg_sel)),
    .wdata    (wcode_t'(cfg_code)),
    .lock     (cfg_lock),
    .w_mid    (w_mid),
    .w_side   (w_side),
    .w_corner (w_corner)
  );

  for (genvar p = 0; p < TAPS; p++) begin : g_tap
    wcode_t wsel;
    if (tap_class(p) == SEL_MID) begin : g_mid
      assign wsel = w_mid;
    end else if (tap_class(p) == SEL_SIDE) begin : g_side
      assign wsel = w_side;
    end else begin : g_corner
      assign wsel = w_corner;
    end
    skdp_shift_term #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_term (
      .pix  (win_pix[p*PIX_W +: PIX_W]),
      .w    (wsel),
      .term (term_c[p*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= win_valid;
  end

  always_ff @(posedge clk) begin
    if (win_valid) term_q <= term_c;
  end

  skdp_add_level #(.N_IN(N1), .W(ACC_W)) u_lvl1 (
    .clk(clk), .rst(rst), .vin(v1), .din(term_q), .vout(v2), .dout(sum2));
  skdp_add_level #(.N_IN(N2), .W(ACC_W)) u_lvl2 (
    .clk(clk), .rst(rst), .vin(v2), .din(sum2), .vout(v3), .dout(sum3));
  skdp_add_level #(.N_IN(N3), .W(ACC_W)) u_lvl3 (
    .clk(clk), .rst(rst), .vin(v3), .din(sum3), .vout(v4), .dout(sum4));
  skdp_add_level #(.N_IN(N4), .W(ACC_W)) u_lvl4 (
    .clk(clk), .rst(rst), .vin(v4), .din(sum4), .vout(dot_valid), .dout(dot_sum));
endmodule

// File: rtl/skdp_checker.sv
module skdp_checker
  import skdp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [CODE_W-1:0] cfg_code,
  input logic              win_valid,
  input logic              dot_valid,
  input logic [ACC_W-1:0]  dot_sum,
  input logic [CODE_W-1:0] w_mid,
  input logic [CODE_W-1:0] w_side,
  input logic [CODE_W-1:0] w_corner
);
  localparam longint MAXV = longint'(TAPS) * ((longint'(1) << PIX_W) - 1)
                            * (longint'(1) << ((1 << SH_W) - 1));

  logic [3:0] hist;
  logic [2:0] since_rst;
  logic       busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      since_rst <= '0;
    end else begin
      hist <= {hist[2:0], win_valid};
      if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
    end
  end

  assign busy = win_valid | (|hist);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5) |-> (dot_valid == $past(win_valid, 5)));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!dot_valid && w_mid == '0 && w_side == '0 && w_corner == '0));

  p_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && busy) |=> ($stable(w_mid) && $stable(w_side) && $stable(w_corner)));

  p_write_mid_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !busy && cfg_sel == 2'd0) |=> (w_mid == $past(cfg_code)));

  p_sel_none_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(w_mid) && $stable(w_side) && $stable(w_corner)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    dot_valid |-> (longint'($signed(dot_sum)) <= MAXV && longint'($signed(dot_sum)) >= -MAXV));
endmodule

bind symkern_dot skdp_checker #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
  .win_valid(win_valid), .dot_valid(dot_valid), .dot_sum(dot_sum),
  .w_mid(w_mid), .w_side(w_side), .w_corner(w_corner));

// File: tb/symkern_dot_tb_top.sv
module symkern_dot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int AW = 20;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [3:0]    cfg_code = '0;
  logic          win_valid = 1'b0;
  logic [9*PW-1:0] win_pix = '0;
  logic          dot_valid;
  logic [AW-1:0] dot_sum;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_req = "R7";

  // behavioural reference state
  int     m_neg[3];
  int     m_sh[3];
  int     m_hist[$];
  bit     pv[1:5];
  longint pd[1:5];

  symkern_dot dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
    .win_valid(win_valid), .win_pix(win_pix), .dot_valid(dot_valid), .dot_sum(dot_sum));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint ref_dot(input logic [9*PW-1:0] px);
    longint s = 0;
    for (int p = 0; p < 9; p++) begin
      int c = (p == 4) ? 0 : ((p % 2 == 1) ? 1 : 2);
      longint wv = longint'(1) << m_sh[c];
      if (m_neg[c] != 0) wv = -wv;
      s += wv * longint'(px[p*PW +: PW]);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int k = 1; k <= 5; k++) begin pv[k] = 0; pd[k] = 0; end
      for (int c = 0; c < 3; c++) begin m_neg[c] = 0; m_sh[c] = 0; end
      m_hist = {0, 0, 0, 0};
    end else begin
      bit busy;
      for (int k = 5; k >= 2; k--) begin pv[k] = pv[k-1]; pd[k] = pd[k-1]; end
      pv[1] = win_valid;
      pd[1] = win_valid ? ref_dot(win_pix) : 0;
      busy = win_valid;
      foreach (m_hist[i]) if (m_hist[i] != 0) busy = 1;
      if (cfg_we && !busy && cfg_sel != 2'd3) begin
        m_neg[cfg_sel] = cfg_code[3];
        m_sh[cfg_sel]  = cfg_code[2:0];
      end
      void'(m_hist.pop_front());
      m_hist.push_back(win_valid ? 1 : 0);
    end
    if (cyc > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      check(dot_valid == pv[5], (cur_req == "R6") ? "R5" : "R8", dot_valid, pv[5]);
      if (pv[5] && dot_valid)
        check(longint'($signed(dot_sum)) == pd[5], cur_req, $signed(dot_sum), pd[5]);
    end
  end

  task automatic step(input bit v, input logic [9*PW-1:0] px,
                      input bit we, input logic [1:0] sel, input logic [3:0] code);
    @(negedge clk);
    win_valid = v; win_pix = px; cfg_we = we; cfg_sel = sel; cfg_code = code;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 2'd0, 4'd0);
  endtask

  task automatic set_w(input logic [1:0] sel, input bit neg, input int sh);
    step(0, '0, 1, sel, {neg, 3'(sh)});
  endtask

  function automatic logic [9*PW-1:0] rand_win();
    logic [9*PW-1:0] r;
    for (int p = 0; p < 9; p++) r[p*PW +: PW] = 8'($urandom_range(0, 255));
    return r;
  endfunction

  function automatic logic [9*PW-1:0] ramp(input int base);
    logic [9*PW-1:0] r;
    for (int p = 0; p < 9; p++) r[p*PW +: PW] = 8'(base + 10 * p);
    return r;
  endfunction

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(dot_valid == 1'b0, "R7", dot_valid, 0);
    cur_req = "R7";
    step(1, ramp(1), 0, 0, 0);   // default +1 everywhere: plain sum
    idle(7);

    // R1/R2: distinct coefficients per position class
    cur_req = "R1";
    set_w(2'd0, 0, 2);   // middle +4
    set_w(2'd1, 1, 0);   // side -1
    set_w(2'd2, 0, 1);   // corner +2
    idle(1);
    step(1, ramp(3), 0, 0, 0);
    step(1, rand_win(), 0, 0, 0);
    step(1, {9{8'd255}}, 0, 0, 0);
    idle(6);
    cur_req = "R2";
    set_w(2'd0, 1, 7);
    set_w(2'd1, 0, 5);
    set_w(2'd2, 1, 3);
    idle(1);
    step(1, ramp(0), 0, 0, 0);
    step(1, rand_win(), 0, 0, 0);
    idle(6);

    // R3: select value 3 changes nothing
    cur_req = "R3";
    set_w(2'd3, 0, 6);
    idle(1);
    step(1, ramp(7), 0, 0, 0);
    idle(6);

    // R4: writes during the in-flight tail are dropped, the 5th cycle is taken
    cur_req = "R4";
    step(1, ramp(2), 1, 2'd0, 4'h1);
    step(0, '0, 1, 2'd1, 4'h2);
    step(0, '0, 1, 2'd2, 4'h3);
    step(0, '0, 1, 2'd0, 4'h4);
    step(0, '0, 1, 2'd1, 4'h5);
    step(0, '0, 1, 2'd2, 4'hE);   // first free cycle: accepted
    idle(1);
    step(1, ramp(5), 0, 0, 0);
    idle(6);

    // R6: extremes
    cur_req = "R6";
    for (int c = 0; c < 3; c++) set_w(2'(c), 0, 7);
    idle(1);
    step(1, {9{8'd255}}, 0, 0, 0);
    idle(6);
    for (int c = 0; c < 3; c++) set_w(2'(c), 1, 7);
    idle(1);
    step(1, {9{8'd255}}, 0, 0, 0);
    step(1, '0, 0, 0, 0);
    idle(6);

    // R5/R8: random bursts with random gaps and coefficient changes
    cur_req = "R5";
    for (int b = 0; b < 30; b++) begin
      for (int c = 0; c < 3; c++) set_w(2'(c), 1'($urandom_range(0, 1)), $urandom_range(0, 7));
      for (int k = 0; k < 12; k++) begin
        step(1, rand_win(), 0, 0, 0);
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 6));
      end
      idle(5);
    end
    idle(8);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule